// File: doc/BRIEF.md
# Interrupt Priority Level Evaluator

This block folds two sources of interrupt requests into one priority level and
one summary vector. The first source is a software request register that the
block holds itself: a write stores only the fifteen bits reserved for software
levels. The second source is a vector of external request lines, of which eleven
bits carry meaning. When asked to evaluate, the block finds the winning level.
It compares that level with the current priority level supplied by the core. If
the winning level is higher, it raises a one-cycle trap request and latches the
summary vector and the level into its status outputs.

Evaluation is requested by a one-cycle strobe. The strobe is captured into a
pending flag. The evaluation itself runs on the following clock edge, which also
consumes the flag. The block also watches an asynchronous-trap request field.
That kind of trap is not delivered here, so a nonzero value seen during an
evaluation raises an "unsupported" pulse in the same cycle slot as the trap.

Top module: `ipl_eval`

## Requirements
- R1: After reset, `trap_o`, `ast_unsup_o`, `summary_o` and `int_id_o` are all zero.
- R2: A write to the software request register keeps only bits 4 through 18 (mask 0x0007FFF0). All other bits written are dropped and never appear in `summary_o` or influence the level.
- R3: A set software bit i (4..18) stands for level i-3, so bit 4 is level 1 and bit 18 is level 15. The highest set bit gives the software level, and every set software bit is reported in the summary.
- R4: A set external bit i in 20..30 stands for level i, and the highest such bit wins. Any active external bit overrides the software level, while the summary carries the bits of both sources. External bits outside 20..30 are ignored.
- R5: A trap is raised only when the computed level is strictly greater than `cur_lvl`. When no trap is raised, `summary_o` and `int_id_o` keep their previous values.
- R6: When a trap is taken, `summary_o` receives the summary vector and `int_id_o` receives the level. `trap_o` is high for exactly the one cycle that follows the evaluation edge.
- R7: With no valid request bit set, the level is 0 and no trap is raised, even when `cur_lvl` is 0.
- R8: A nonzero `ast_req` at an evaluation edge raises `ast_unsup_o` for the next cycle, which is the same cycle as a trap from that evaluation. It does not suppress the trap.
- R9: A strobe on `eval_req` at clock edge k causes exactly one evaluation, at edge k+1, using the inputs present there. Strobes on consecutive edges give one evaluation each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Write enable of the software request register |
| sw_wdata | input | 32 | Data written to the software request register |
| ext_req | input | 32 | External interrupt request lines |
| cur_lvl | input | 5 | Current interrupt priority level |
| ast_req | input | 4 | Asynchronous-trap request field |
| eval_req | input | 1 | Evaluate strobe |
| trap_o | output | 1 | Interrupt trap request pulse |
| ast_unsup_o | output | 1 | Unsupported asynchronous-trap request pulse |
| summary_o | output | 32 | Latched interrupt summary vector |
| int_id_o | output | 5 | Latched interrupt level |

## Verification
The trap pulse and the unsupported flag can both come from a single evaluation.
The bench provokes this by loading a software request above the current level
while `ast_req` is nonzero. It judges that both pulses appear in the same cycle
and that the latched level and summary are correct. A second run keeps
`cur_lvl` above the request, so the flag must appear without the trap. Strobes
on back-to-back edges are also driven, so that one evaluation consumes the
pending flag on the same edge that another strobe sets it again.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
    localparam int REQ_W  = 32;
    localparam int LVL_W  = 5;
    localparam int AST_W  = 4;
    localparam int SW_LO  = 4;
    localparam int SW_HI  = 18;
    localparam int EXT_LO = 20;
    localparam int EXT_HI = 30;

    // Contiguous bit mask from lo to hi inclusive.
    function automatic logic [REQ_W-1:0] span_mask(input int lo, input int hi);
        logic [REQ_W-1:0] m;
        m = '0;
        for (int b = 0; b < REQ_W; b++) begin
            if (b >= lo && b <= hi) m[b] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REQ_W-1:0] SW_MASK  = span_mask(SW_LO, SW_HI);
    localparam logic [REQ_W-1:0] EXT_MASK = span_mask(EXT_LO, EXT_HI);

    // Result of scanning one request source.
    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
        logic [REQ_W-1:0] sum;
    } ipl_cand_t;
endpackage

// File: rtl/ipl_swreq_reg.sv
module ipl_swreq_reg
    import ipl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REQ_W-1:0] wdata,
    output logic [REQ_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & SW_MASK;
        end
    end
endmodule

// File: rtl/ipl_range_scan.sv
module ipl_range_scan
    import ipl_pkg::*;
#(
    parameter int LO   = SW_LO,
    parameter int HI   = SW_HI,
    parameter int BASE = SW_LO - 1
) (
    input  logic [REQ_W-1:0] req,
    output ipl_cand_t        cand
);
    localparam logic [REQ_W-1:0] MASK = span_mask(LO, HI);

    // Level that each bit position stands for.
    logic [LVL_W-1:0] bit_lvl [LO:HI];

    genvar g;
    generate
        for (g = LO; g <= HI; g++) begin : g_lvl
            assign bit_lvl[g] = LVL_W'(g - BASE);
        end
    endgenerate

    // Ascending scan: the highest active bit is the last one written.
    always_comb begin
        cand.hit = 1'b0;
        cand.lvl = '0;
        cand.sum = req & MASK;
        for (int i = LO; i <= HI; i++) begin
            if (req[i]) begin
                cand.hit = 1'b1;
                cand.lvl = bit_lvl[i];
            end
        end
    end
endmodule

// File: rtl/ipl_merge.sv
module ipl_merge
    import ipl_pkg::*;
(
    input  ipl_cand_t        sw_c,
    input  ipl_cand_t        ext_c,
    input  logic [LVL_W-1:0] cur_lvl,
    output ipl_cand_t        win,
    output logic             fire
);
    always_comb begin
        win.hit = sw_c.hit | ext_c.hit;
        win.lvl = ext_c.hit ? ext_c.lvl : sw_c.lvl;
        win.sum = sw_c.sum | ext_c.sum;
        fire    = win.hit && (win.lvl != '0) && (win.lvl > cur_lvl);
    end
endmodule

// File: rtl/ipl_eval.sv
module ipl_eval
    import ipl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [REQ_W-1:0] sw_wdata,
    input  logic [REQ_W-1:0] ext_req,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic [AST_W-1:0] ast_req,
    input  logic             eval_req,
    output logic             trap_o,
    output logic             ast_unsup_o,
    output logic [REQ_W-1:0] summary_o,
    output logic [LVL_W-1:0] int_id_o
);
    logic [REQ_W-1:0] sw_q;
    ipl_cand_t        sw_c;
    ipl_cand_t        ext_c;
    ipl_cand_t        win;
    logic             fire;
    logic             pend_q;

    ipl_swreq_reg u_swreg (
        .clk   (clk),
        .rst   (rst),
        .we    (sw_we),
        .wdata (sw_wdata),
        .q     (sw_q)
    );

    ipl_range_scan #(.LO(SW_LO), .HI(SW_HI), .BASE(SW_LO - 1)) u_sw_scan (
        .req  (sw_q),
        .cand (sw_c)
    );

    ipl_range_scan #(.LO(EXT_LO), .HI(EXT_HI), .BASE(0)) u_ext_scan (
        .req  (ext_req),
        .cand (ext_c)
    );

    ipl_merge u_merge (
        .sw_c    (sw_c),
        .ext_c   (ext_c),
        .cur_lvl (cur_lvl),
        .win     (win),
        .fire    (fire)
    );

    // Pending flag: set by the strobe, consumed by the evaluation it triggers.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            trap_o      <= 1'b0;
            ast_unsup_o <= 1'b0;
            summary_o   <= '0;
            int_id_o    <= '0;
        end else begin
            pend_q      <= eval_req;
            trap_o      <= pend_q && fire;
            ast_unsup_o <= pend_q && (ast_req != '0);
            if (pend_q && fire) begin
                summary_o <= win.sum;
                int_id_o  <= win.lvl;
            end
        end
    end
endmodule

// File: rtl/ipl_eval_chk.sv
module ipl_eval_chk
    import ipl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             eval_req,
    input logic [LVL_W-1:0] cur_lvl,
    input logic [AST_W-1:0] ast_req,
    input logic             trap_o,
    input logic             ast_unsup_o,
    input logic [REQ_W-1:0] summary_o,
    input logic [LVL_W-1:0] int_id_o
);
    // R9
    trap_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> $past(eval_req, 2));

    // R5
    trap_above_cur_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (int_id_o > $past(cur_lvl)));

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> ($stable(summary_o) && $stable(int_id_o)));

    // R2
    summary_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (summary_o & ~(SW_MASK | EXT_MASK)) == '0);

    // R4
    ext_level_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_o && ((summary_o & EXT_MASK) != '0)) |-> (int_id_o >= LVL_W'(EXT_LO)));

    // R8
    ast_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ast_unsup_o |-> ($past(eval_req, 2) && ($past(ast_req) != '0)));
endmodule

bind ipl_eval ipl_eval_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .eval_req    (eval_req),
    .cur_lvl     (cur_lvl),
    .ast_req     (ast_req),
    .trap_o      (trap_o),
    .ast_unsup_o (ast_unsup_o),
    .summary_o   (summary_o),
    .int_id_o    (int_id_o)
);

// File: tb/ipl_eval_bench.sv
`timescale 1ns/1ps
module ipl_eval_bench;
    import ipl_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             sw_we;
    logic [REQ_W-1:0] sw_wdata;
    logic [REQ_W-1:0] ext_req;
    logic [LVL_W-1:0] cur_lvl;
    logic [AST_W-1:0] ast_req;
    logic             eval_req;
    logic             trap_o;
    logic             ast_unsup_o;
    logic [REQ_W-1:0] summary_o;
    logic [LVL_W-1:0] int_id_o;

    int total = 0;
    int bad   = 0;
    logic [REQ_W-1:0] exp_sum = '0;
    logic [LVL_W-1:0] exp_id  = '0;

    always #4 clk = ~clk;

    ipl_eval u_ipl_eval (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .ext_req(ext_req), .cur_lvl(cur_lvl), .ast_req(ast_req),
        .eval_req(eval_req), .trap_o(trap_o), .ast_unsup_o(ast_unsup_o),
        .summary_o(summary_o), .int_id_o(int_id_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_sw(input logic [REQ_W-1:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    // Strobe, then sample in the cycle after the evaluation edge.
    task automatic eval_check(input string tag, input logic exp_trap, input logic exp_ast);
        @(negedge clk);
        eval_req = 1'b1;
        @(negedge clk);
        eval_req = 1'b0;
        chk({tag, " R9 no early trap"}, 64'(trap_o), 64'd0);
        @(negedge clk);
        chk({tag, " R6 trap"}, 64'(trap_o), 64'(exp_trap));
        chk({tag, " R8 ast"}, 64'(ast_unsup_o), 64'(exp_ast));
        chk({tag, " R6 summary"}, 64'(summary_o), 64'(exp_sum));
        chk({tag, " R6 id"}, 64'(int_id_o), 64'(exp_id));
        @(negedge clk);
        chk({tag, " R6 single pulse"}, 64'(trap_o), 64'd0);
    endtask

    task automatic t_reset();
        // R1
        chk("R1 trap", 64'(trap_o), 64'd0);
        chk("R1 ast", 64'(ast_unsup_o), 64'd0);
        chk("R1 summary", 64'(summary_o), 64'd0);
        chk("R1 id", 64'(int_id_o), 64'd0);
    endtask

    task automatic t_sw_mask();
        // R2: all ones written, only bits 4..18 kept -> level 15
        write_sw(32'hFFFF_FFFF);
        exp_sum = 32'h0007_FFF0; exp_id = 5'd15;
        eval_check("R2 mask", 1'b1, 1'b0);
    endtask

    task automatic t_sw_levels();
        // R3: bit 4 -> level 1
        write_sw(32'h0000_0010);
        exp_sum = 32'h0000_0010; exp_id = 5'd1;
        eval_check("R3 bit4", 1'b1, 1'b0);
        // R3: bits 7 and 12 -> level 9, both in summary
        write_sw(32'h0000_1080);
        exp_sum = 32'h0000_1080; exp_id = 5'd9;
        eval_check("R3 bits7_12", 1'b1, 1'b0);
    endtask

    task automatic t_ext();
        // R4: external bit 20 overrides software level 15
        write_sw(32'h0004_0000);
        ext_req = 32'h0010_0000;
        exp_sum = 32'h0014_0000; exp_id = 5'd20;
        eval_check("R4 override", 1'b1, 1'b0);
        // R4: bits 22 and 30 -> 30
        write_sw('0);
        ext_req = 32'h4040_0000;
        exp_sum = 32'h4040_0000; exp_id = 5'd30;
        eval_check("R4 high", 1'b1, 1'b0);
        // R4: bits 31, 19, 3 ignored -> no trap, status held
        ext_req = 32'h8008_0008;
        eval_check("R4 ignored", 1'b0, 1'b0);
        ext_req = '0;
    endtask

    task automatic t_threshold();
        // R5: bit 10 -> level 7; equal current level gives no trap
        write_sw(32'h0000_0400);
        cur_lvl = 5'd7;
        eval_check("R5 equal", 1'b0, 1'b0);
        cur_lvl = 5'd6;
        exp_sum = 32'h0000_0400; exp_id = 5'd7;
        eval_check("R5 above", 1'b1, 1'b0);
        cur_lvl = 5'd0;
    endtask

    task automatic t_empty();
        // R7
        write_sw('0);
        ext_req = '0;
        eval_check("R7 empty", 1'b0, 1'b0);
    endtask

    task automatic t_ast();
        // R8: trap and unsupported flag in the same cycle
        write_sw(32'h0000_0020);
        ast_req = 4'h3;
        exp_sum = 32'h0000_0020; exp_id = 5'd2;
        eval_check("R8 both", 1'b1, 1'b1);
        // R8: flag alone when level too low
        cur_lvl = 5'd20;
        eval_check("R8 flag only", 1'b0, 1'b1);
        cur_lvl = 5'd0;
        ast_req = '0;
    endtask

    task automatic t_once();
        // R9: one strobe, one evaluation
        write_sw(32'h0000_0100);
        exp_sum = 32'h0000_0100; exp_id = 5'd5;
        eval_check("R9 once", 1'b1, 1'b0);
        repeat (3) begin
            @(negedge clk);
            chk("R9 no repeat", 64'(trap_o), 64'd0);
        end
        // R9: two consecutive strobes -> two consecutive traps
        @(negedge clk); eval_req = 1'b1;
        @(negedge clk);
        @(negedge clk); eval_req = 1'b0;
        chk("R9 b2b first", 64'(trap_o), 64'd1);
        @(negedge clk);
        chk("R9 b2b second", 64'(trap_o), 64'd1);
        @(negedge clk);
        chk("R9 b2b end", 64'(trap_o), 64'd0);
    endtask

    initial begin
        rst = 1'b1; sw_we = 1'b0; sw_wdata = '0; ext_req = '0;
        cur_lvl = '0; ast_req = '0; eval_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sw_mask();
        t_sw_levels();
        t_ext();
        t_threshold();
        t_empty();
        t_ast();
        t_once();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule